// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block runs one instruction that moves several registers to or from memory, for a 32-bit core with sixteen general registers. A start strobe supplies the base register index, a 16-bit selection mask, the base address and four mode flags: pre or post stepping, ascending or descending direction, base update, and load or store. A rule-set select picks between an older and a newer revision of the base-conflict rules. The block samples all of these once and then issues one word request per selected register over a valid/ready memory handshake.

Stores read their data from a combinational register-file read port. Loads return data through a register-file write port in the same cycle the memory accepts the request. When the transfer ends, a single-cycle done pulse appears. In that same cycle the block may present a base-register update, whose value depends on the direction, on whether the base register is in the mask, and on the selected rule revision.

Top module: `blockXferSeq`

## Requirements
- R1: With N equal to the number of set bits in the mask, the updated base is base+4N when ascending and base−4N when descending.
- R2: The first address is base+4 for ascending pre-step, base for ascending post-step, base−4N for descending pre-step, and base−4N+4 for descending post-step.
- R3: Registers go out in ascending index order at word addresses that rise by 4, one transfer for each accepted handshake, with `rfRdIdx` naming the register being moved.
- R4: The last address moved is base+4N for ascending pre-step, base+4N−4 for ascending post-step, base−4 for descending pre-step, and base for descending post-step.
- R5: A store with base update whose base register is not in the mask writes the updated base to the base register.
- R6: A store with base update under the older rules, with the base register in the mask, writes the old base if no lower mask bit is set and the updated base otherwise.
- R7: A store with base update under the newer rules, with the base register in the mask, always writes the old base.
- R8: A load with base update under the newer rules, with the base register in the mask, writes the updated base only if the base register is the sole mask bit or is not the highest set bit. Otherwise the loaded value stays.
- R9: A load with base update under the older rules, with the base register in the mask, performs no base update.
- R10: With base update off, `wbEn` never rises.
- R11: `doneO` is a one-cycle pulse one cycle after the final accepted transfer. An empty mask gives no transfers, `doneO` one cycle after start, and no base update.
- R12: Stored data is the register content from before the instruction, including a stored copy of the base register.
- R13: While `memReady` is low, the request address and index hold steady. A start that arrives while busy is ignored.
- R14: For a load, `rfWrEn` pulses on each accepted transfer with the memory data and the register index. `memWrite` is 1 for stores and 0 for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Start strobe, sampled when idle |
| baseIdx | input | 4 | Base register index |
| regList | input | 16 | Register selection mask |
| baseAddr | input | 32 | Base address |
| preStep | input | 1 | 1: step before access, 0: after |
| ascend | input | 1 | 1: ascending, 0: descending |
| wrBack | input | 1 | Base update requested |
| isLoad | input | 1 | 1: load, 0: store |
| newArch | input | 1 | 1: newer conflict rules, 0: older |
| busyO | output | 1 | Instruction in progress |
| doneO | output | 1 | Completion pulse |
| memValid | output | 1 | Memory request valid |
| memAddr | output | 32 | Word address of request |
| memWrite | output | 1 | Request is a write |
| memWdata | output | 32 | Store data |
| memReady | input | 1 | Memory accepts request |
| memRdata | input | 32 | Load data, valid with memReady |
| rfRdIdx | output | 4 | Register read index for the current transfer |
| rfRdData | input | 32 | Register read data |
| rfWrEn | output | 1 | Load data write enable |
| rfWrIdx | output | 4 | Load data register index |
| rfWrData | output | 32 | Load data |
| wbEn | output | 1 | Base update enable |
| wbIdx | output | 4 | Base update register index |
| wbValue | output | 32 | Base update value |

## Verification
The bench goes after the base-conflict corners: the base register lowest in the mask, in the middle, highest, and alone, under both rule revisions for loads and stores. A design with a wrong first/last test or a swapped revision puts the wrong base value into the register, or clobbers loaded data, and the base value check flags it. It also covers all four stepping modes, including a descending run that wraps below address zero, and compares every request address and the final address. An off-by-one start offset shifts every address. Stalled handshakes, a start strobe held during a transfer, and an empty mask catch a sequencer that advances without acceptance, restarts mid-run, or never produces its done pulse.

// File: rtl/blockXferPkg.sv
package blockXferPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic advance;
    logic finish;
  } xferStrobes_t;

endpackage

// File: rtl/blockXferCtrl.sv
module blockXferCtrl
  import blockXferPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startI,
  input  logic         listEmpty,
  input  logic         lastOne,
  input  logic         memReady,
  output xferStrobes_t strb,
  output logic         memValid,
  output logic         doneO,
  output logic         busyO
);

  seqState_t st, stNext;

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  always_comb begin
    stNext = st;
    strb   = '0;
    case (st)
      ST_IDLE: begin
        if (startI) begin
          strb.capture = 1'b1;
          stNext = listEmpty ? ST_FIN : ST_XFER;
        end
      end
      ST_XFER: begin
        if (memReady) begin
          strb.advance = 1'b1;
          if (lastOne) stNext = ST_FIN;
        end
      end
      ST_FIN: begin
        strb.finish = 1'b1;
        stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign memValid = (st == ST_XFER);
  assign doneO    = (st == ST_FIN);
  assign busyO    = (st != ST_IDLE);

endmodule

// File: rtl/blockXferPath.sv
module blockXferPath
  import blockXferPkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  xferStrobes_t             strb,
  input  logic [$clog2(NREG)-1:0]  baseIdx,
  input  logic [NREG-1:0]          regList,
  input  logic [AW-1:0]            baseAddr,
  input  logic                     preStep,
  input  logic                     ascend,
  input  logic                     wrBack,
  input  logic                     isLoad,
  input  logic                     newArch,
  input  logic [DW-1:0]            memRdata,
  input  logic [DW-1:0]            rfRdData,
  output logic                     listEmpty,
  output logic                     lastOne,
  output logic [AW-1:0]            memAddr,
  output logic                     memWrite,
  output logic [DW-1:0]            memWdata,
  output logic [$clog2(NREG)-1:0]  rfRdIdx,
  output logic                     rfWrEn,
  output logic [$clog2(NREG)-1:0]  rfWrIdx,
  output logic [DW-1:0]            rfWrData,
  output logic                     wbEn,
  output logic [$clog2(NREG)-1:0]  wbIdx,
  output logic [AW-1:0]            wbValue
);

  localparam int IDXW     = $clog2(NREG);
  localparam int CNTW     = $clog2(NREG + 1);
  localparam int WBYTES   = DW / 8;
  localparam int WSHIFT   = $clog2(WBYTES);
  localparam logic [AW-1:0] STEP = AW'(WBYTES);

  function automatic logic [IDXW-1:0] lowestSet(input logic [NREG-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  logic [NREG-1:0] remList;
  logic [AW-1:0]   curAddr;
  logic [IDXW-1:0] baseIdxLat;
  logic            loadLat;
  logic            wbWantLat;
  logic [AW-1:0]   wbValLat;

  logic [CNTW-1:0] regCount;
  logic [AW-1:0]   span;
  logic [AW-1:0]   newBase;
  logic [AW-1:0]   firstAddr;
  logic [NREG-1:0] belowMask;
  logic            inList, isFirst, isLast, isOnly;
  logic            wbWant;
  logic [AW-1:0]   wbPick;

  // Per-instruction arithmetic, evaluated on the sampled inputs
  always_comb begin
    regCount  = CNTW'($countones(regList));
    span      = AW'(regCount) << WSHIFT;
    newBase   = ascend ? (baseAddr + span) : (baseAddr - span);
    if (ascend) firstAddr = preStep ? (baseAddr + STEP) : baseAddr;
    else        firstAddr = preStep ? (baseAddr - span) : (baseAddr - span + STEP);
  end

  // Base-conflict rules
  always_comb begin
    belowMask = (NREG'(1) << baseIdx) - NREG'(1);
    inList    = regList[baseIdx];
    isFirst   = (regList & belowMask) == '0;
    isLast    = (regList >> baseIdx) == NREG'(1);
    isOnly    = regCount == CNTW'(1);
    wbWant    = 1'b0;
    wbPick    = newBase;
    if (wrBack && (regList != '0)) begin
      if (!inList) begin
        wbWant = 1'b1;
      end else if (!isLoad) begin
        wbWant = 1'b1;
        if (newArch || isFirst) wbPick = baseAddr;
      end else if (newArch && (isOnly || !isLast)) begin
        wbWant = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remList    <= '0;
      curAddr    <= '0;
      baseIdxLat <= '0;
      loadLat    <= 1'b0;
      wbWantLat  <= 1'b0;
      wbValLat   <= '0;
    end else if (strb.capture) begin
      remList    <= regList;
      curAddr    <= firstAddr;
      baseIdxLat <= baseIdx;
      loadLat    <= isLoad;
      wbWantLat  <= wbWant;
      wbValLat   <= wbPick;
    end else if (strb.advance) begin
      remList    <= remList & (remList - NREG'(1));
      curAddr    <= curAddr + STEP;
    end
  end

  assign listEmpty = (regList == '0);
  assign lastOne   = (remList & (remList - NREG'(1))) == '0;
  assign rfRdIdx   = lowestSet(remList);
  assign memAddr   = curAddr;
  assign memWrite  = !loadLat;
  assign memWdata  = rfRdData;
  assign rfWrEn    = strb.advance && loadLat;
  assign rfWrIdx   = rfRdIdx;
  assign rfWrData  = memRdata;
  assign wbEn      = strb.finish && wbWantLat;
  assign wbIdx     = baseIdxLat;
  assign wbValue   = wbValLat;

endmodule

// File: rtl/blockXferSeq.sv
module blockXferSeq
  import blockXferPkg::*;
#(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    startI,
  input  logic [$clog2(NREG)-1:0] baseIdx,
  input  logic [NREG-1:0]         regList,
  input  logic [AW-1:0]           baseAddr,
  input  logic                    preStep,
  input  logic                    ascend,
  input  logic                    wrBack,
  input  logic                    isLoad,
  input  logic                    newArch,
  output logic                    busyO,
  output logic                    doneO,
  output logic                    memValid,
  output logic [AW-1:0]           memAddr,
  output logic                    memWrite,
  output logic [DW-1:0]           memWdata,
  input  logic                    memReady,
  input  logic [DW-1:0]           memRdata,
  output logic [$clog2(NREG)-1:0] rfRdIdx,
  input  logic [DW-1:0]           rfRdData,
  output logic                    rfWrEn,
  output logic [$clog2(NREG)-1:0] rfWrIdx,
  output logic [DW-1:0]           rfWrData,
  output logic                    wbEn,
  output logic [$clog2(NREG)-1:0] wbIdx,
  output logic [AW-1:0]           wbValue
);

  xferStrobes_t strb;
  logic listEmpty, lastOne;

  blockXferCtrl uCtrl (
    .clk(clk), .rstN(rstN), .startI(startI),
    .listEmpty(listEmpty), .lastOne(lastOne), .memReady(memReady),
    .strb(strb), .memValid(memValid), .doneO(doneO), .busyO(busyO)
  );

  blockXferPath #(.NREG(NREG), .AW(AW), .DW(DW)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .baseIdx(baseIdx), .regList(regList), .baseAddr(baseAddr),
    .preStep(preStep), .ascend(ascend), .wrBack(wrBack),
    .isLoad(isLoad), .newArch(newArch),
    .memRdata(memRdata), .rfRdData(rfRdData),
    .listEmpty(listEmpty), .lastOne(lastOne),
    .memAddr(memAddr), .memWrite(memWrite), .memWdata(memWdata),
    .rfRdIdx(rfRdIdx), .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx),
    .rfWrData(rfWrData), .wbEn(wbEn), .wbIdx(wbIdx), .wbValue(wbValue)
  );

endmodule

// File: rtl/blockXferChk.sv
module blockXferChk #(
  parameter int NREG = 16,
  parameter int AW   = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    startI,
  input logic                    busyO,
  input logic                    doneO,
  input logic                    memValid,
  input logic [AW-1:0]           memAddr,
  input logic                    memWrite,
  input logic                    memReady,
  input logic [$clog2(NREG)-1:0] rfRdIdx,
  input logic                    rfWrEn,
  input logic                    wbEn
);

  a_r13_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(rfRdIdx)));

  a_r13_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && startI) |=> busyO);

  a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (!memValid || memAddr == $past(memAddr) + AW'(4)));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady) |=> (!memValid || rfRdIdx > $past(rfRdIdx)));

  a_r14_write_port: assert property (@(posedge clk) disable iff (!rstN)
    rfWrEn |-> (memValid && memReady && !memWrite));

  a_r11_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneO |=> !doneO);

  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    doneO |-> !memValid);

  a_r10_wb_at_done: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> doneO);

endmodule

bind blockXferSeq blockXferChk #(.NREG(NREG), .AW(AW)) uChk (.*);

// File: tb/sim_blockXferSeq.sv
`timescale 1ns/1ps
module sim_blockXferSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic [3:0]  baseIdx = '0;
  logic [15:0] regList = '0;
  logic [31:0] baseAddr = '0;
  logic        preStep = 1'b0, ascend = 1'b0, wrBack = 1'b0, isLoad = 1'b0, newArch = 1'b0;
  logic        busyO, doneO, memValid, memWrite, memReady = 1'b0;
  logic [31:0] memAddr, memWdata, memRdata, rfRdData, rfWrData, wbValue;
  logic [3:0]  rfRdIdx, rfWrIdx, wbIdx;
  logic        rfWrEn, wbEn;

  localparam logic [31:0] RD_MIX = 32'hC3C3_0000;

  int compared = 0;
  int mismatched = 0;
  int stallCnt = 0;
  logic [31:0] rfMem [16];
  logic [31:0] refRf [16];

  always #4 clk = ~clk;

  blockXferSeq u0 (
    .clk(clk), .rstN(rstN), .startI(startI), .baseIdx(baseIdx), .regList(regList),
    .baseAddr(baseAddr), .preStep(preStep), .ascend(ascend), .wrBack(wrBack),
    .isLoad(isLoad), .newArch(newArch), .busyO(busyO), .doneO(doneO),
    .memValid(memValid), .memAddr(memAddr), .memWrite(memWrite), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
    .rfWrEn(rfWrEn), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData),
    .wbEn(wbEn), .wbIdx(wbIdx), .wbValue(wbValue)
  );

  // Environment: memory returns a function of the address, register file is an array
  assign memRdata = memAddr ^ RD_MIX;
  assign rfRdData = rfMem[rfRdIdx];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 16; i++) rfMem[i] <= 32'h1111_0000 * i + i;
    end else begin
      if (rfWrEn) rfMem[rfWrIdx] <= rfWrData;
      if (wbEn)   rfMem[wbIdx]   <= wbValue;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runOp(input int bi, input logic [15:0] lst, input logic [31:0] base,
                       input bit p, input bit u, input bit w, input bit l, input bit arch,
                       input int rmode, input bit spurious);
    int qIdx[$];
    logic [31:0] qAddr[$];
    int cnt, k;
    logic [31:0] newB, lowA, endA, lastA, expVal, rd;
    bit inList, first, last, expWb, ready;
    string wbTag;

    cnt  = $countones(lst);
    newB = u ? base + 32'(4 * cnt) : base - 32'(4 * cnt);
    if (u) lowA = p ? base + 32'd4 : base;
    else   lowA = p ? base - 32'(4 * cnt) : base - 32'(4 * cnt) + 32'd4;
    if (u) endA = p ? base + 32'(4 * cnt) : base + 32'(4 * cnt) - 32'd4;
    else   endA = p ? base - 32'd4 : base;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        qIdx.push_back(i);
        qAddr.push_back(lowA + 32'(4 * k));
        k++;
      end
    end
    inList = lst[bi];
    first  = 1'b1;
    for (int i = 0; i < bi; i++) if (lst[i]) first = 1'b0;
    last   = 1'b1;
    for (int i = bi + 1; i < 16; i++) if (lst[i]) last = 1'b0;
    expWb  = 1'b0;
    expVal = newB;
    if (!w)             wbTag = "R10";
    else if (cnt == 0)  wbTag = "R11";
    else if (!inList) begin
      wbTag = "R5 R1"; expWb = 1'b1;
    end else if (!l) begin
      expWb = 1'b1;
      if (arch) begin wbTag = "R7"; expVal = base; end
      else begin wbTag = "R6"; if (first) expVal = base; end
    end else if (arch) begin
      wbTag = "R8"; expWb = (cnt == 1) || !last;
    end else begin
      wbTag = "R9";
    end

    @(negedge clk);
    baseIdx = 4'(bi); regList = lst; baseAddr = base;
    preStep = p; ascend = u; wrBack = w; isLoad = l; newArch = arch;
    startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    k = 0;
    lastA = '0;
    while (k < qIdx.size()) begin
      ready = (rmode == 0) || (stallCnt % 3 == 2);
      stallCnt++;
      memReady = ready;
      if (spurious) begin startI = 1'b1; regList = 16'h0001; end
      #1;
      chk(ready ? "R3 valid" : "R13 valid held", 32'(memValid), 32'd1);
      chk(k == 0 ? "R2 address" : (ready ? "R3 address" : "R13 address held"), memAddr, qAddr[k]);
      chk("R3 index", 32'(rfRdIdx), 32'(qIdx[k]));
      chk("R14 direction", 32'(memWrite), 32'(!l));
      if (!l) chk("R12 store data", memWdata, refRf[qIdx[k]]);
      chk("R14 write enable", 32'(rfWrEn), 32'(ready && l));
      chk("R11 no early done", 32'(doneO), 32'd0);
      if (ready) begin
        if (l) begin
          rd = qAddr[k] ^ RD_MIX;
          chk("R14 write data", rfWrData, rd);
          chk("R14 write index", 32'(rfWrIdx), 32'(qIdx[k]));
          refRf[qIdx[k]] = rd;
        end
        lastA = qAddr[k];
        k++;
      end
      @(negedge clk);
    end
    startI = 1'b0;
    memReady = 1'b0;
    #1;
    chk("R11 done pulse", 32'(doneO), 32'd1);
    chk("R11 no request at done", 32'(memValid), 32'd0);
    chk(wbTag, 32'(wbEn), 32'(expWb));
    if (expWb) begin
      chk({wbTag, " value"}, wbValue, expVal);
      chk({wbTag, " index"}, 32'(wbIdx), 32'(bi));
      refRf[bi] = expVal;
    end
    if (cnt > 0) chk("R4 end address", lastA, endA);
    @(negedge clk);
    #1;
    chk("R11 done single cycle", 32'(doneO), 32'd0);
    chk("R11 idle after done", 32'(busyO), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R3 watchdog expired: actual=hung expected=complete");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) refRf[i] = 32'h1111_0000 * i + i;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset done", 32'(doneO), 32'd0);
    chk("R3 reset valid", 32'(memValid), 32'd0);
    chk("R10 reset wb", 32'(wbEn), 32'd0);
    rstN = 1'b1;
    // bi, list, base, P, U, W, L, arch, readyMode, spuriousStart
    runOp(2,  16'h00F0, 32'h0000_1000, 0, 1, 1, 0, 0, 0, 0); // R5 R1 ascending post
    runOp(4,  16'h0070, 32'h0000_2000, 1, 1, 1, 0, 0, 0, 0); // R6 first in list
    runOp(5,  16'h0031, 32'h0000_3000, 1, 0, 1, 0, 0, 1, 0); // R6 not first, stalls R13
    runOp(5,  16'h0031, 32'h0000_3000, 1, 0, 1, 0, 1, 0, 0); // R7
    runOp(7,  16'h00C0, 32'h0000_4000, 0, 0, 1, 1, 1, 0, 0); // R8 base highest
    runOp(3,  16'h0108, 32'h0000_5000, 1, 1, 1, 1, 1, 1, 0); // R8 not highest
    runOp(9,  16'h0200, 32'h0000_6000, 0, 1, 1, 1, 1, 0, 0); // R8 sole register
    runOp(1,  16'h0006, 32'h0000_7000, 0, 1, 1, 1, 0, 0, 0); // R9
    runOp(0,  16'hFFFE, 32'h0000_8000, 1, 1, 1, 1, 0, 1, 1); // R5 load, R13 start while busy
    runOp(6,  16'h8041, 32'h0000_9000, 1, 0, 0, 0, 1, 0, 0); // R10 no update
    runOp(3,  16'h0000, 32'h0000_A000, 1, 1, 1, 0, 0, 0, 0); // R11 empty mask
    runOp(15, 16'hFFFF, 32'h0001_0000, 0, 0, 1, 0, 1, 1, 0); // R7 full list descending post
    runOp(2,  16'h000F, 32'h0000_0008, 1, 0, 1, 0, 0, 0, 0); // R2 R4 wrap below zero, R6 not first
    runOp(0,  16'h0101, 32'h0000_B000, 0, 1, 1, 0, 0, 0, 0); // R12 stores updated values, R6 first
    summary();
    $finish;
  end

endmodule